// File: doc/BRIEF.md
# Shared I2C Pool Byte Memory

This block holds the byte storage that a group of I2C bus engines use to stage the bytes of a multi-byte command sequence. A host register interface reaches the whole storage with accesses of one to four bytes at any byte address. Each bus engine reaches only its own window through a single-byte port, giving its bus number and a byte index into the window. The block turns that pair into a storage address.

The window placement is fixed at build time by a mapping-mode parameter, and the storage depth follows from that mode. In the paged mode the window base combines a 3-bit page number and a 6-bit word offset, both taken from the requesting bus's register fields. The two fixed modes cut the storage into equal slices indexed by bus number. The host and the engines share one storage array. When both ask in the same cycle the host is served, and the engine request is held off through its valid/ready handshake.

The storage is split into four byte-wide banks interleaved on the low two address bits. An unaligned four-byte host access therefore touches each bank exactly once and completes in a single cycle.

Top module: `i2c_pool_sram`

## Requirements
- R1: After synchronous reset, `host_rvalid` and `eng_rvalid` are low, and `eng_ready` is high while `host_req` is low.
- R2: A host access of `host_size`+1 bytes (code 0 to 3 gives 1 to 4 bytes) moves data byte i (bits 8i+7:8i) to or from storage address `host_addr`+i. Read data appears with `host_rvalid` high in the cycle after the request, and bytes at or above the access size read as zero.
- R3: Host accesses work at every byte alignment, and a write changes only the bytes it covers.
- R4: Storage depth is 2048 bytes in paged mode, 256 bytes in fixed-16 mode and 512 bytes in fixed-32 mode. Host bytes whose address is at or beyond the depth read as zero, and the write bytes that fall there are dropped. They do not wrap onto low addresses.
- R5: In paged mode the engine byte address is page×256 + offset×4 + index. Bus n takes its page from `bus_page[3n+2:3n]` and its offset from `bus_off[6n+5:6n]`.
- R6: In fixed-16 mode the engine byte address of bus n is n×16 + index.
- R7: In fixed-32 mode the engine byte address of bus n is n×32 + index.
- R8: An engine address that reaches past the storage end wraps modulo the depth.
- R9: When `host_req` is high, `eng_ready` is low and the engine request is not carried out. The engine request is accepted in the first cycle with `host_req` low.
- R10: An accepted engine read returns the addressed byte on `eng_rdata` with `eng_rvalid` high one cycle later. An accepted engine write stores `eng_wdata` where both ports later read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, served in the same cycle |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | HOST_AW | Host byte address of data byte 0 |
| host_size | input | 2 | Access size minus one, in bytes |
| host_wdata | input | 32 | Host write data, little-endian lanes |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data, little-endian lanes |
| eng_valid | input | 1 | Engine byte request |
| eng_ready | output | 1 | Engine request accepted this cycle |
| eng_we | input | 1 | Engine write when high |
| eng_bus | input | BUS_W | Requesting bus number |
| eng_idx | input | IDX_W | Byte index inside the bus window |
| eng_wdata | input | 8 | Engine write byte |
| eng_rvalid | output | 1 | Engine read byte valid |
| eng_rdata | output | 8 | Engine read byte |
| bus_page | input | NUM_BUS*3 | Per-bus page numbers, 3 bits per bus |
| bus_off | input | NUM_BUS*6 | Per-bus word offsets, 6 bits per bus |

## Verification
The bench builds all three mapping modes side by side and sweeps every host byte address with rotating access sizes. A lane rotation error would put bytes into the wrong positions of `host_rdata`. An unmasked size would leak stale upper bytes. Accesses that straddle the end of each depth show whether a design wraps its host bytes: such a design would overwrite address 0 or return non-zero data past the end. Every bus is driven through a spread of indices up to 255, and the paged mode uses page/offset pairs that overflow 2048. These catch a swapped page/offset weighting and a missing modulo, which would read from the wrong window. A simultaneous host and engine request shows whether the engine is served twice, served in place of the host, or never served.

// File: rtl/pool_pkg.sv
package pool_pkg;

  typedef enum logic [1:0] {
    MAP_PAGED   = 2'd0,
    MAP_FIXED16 = 2'd1,
    MAP_FIXED32 = 2'd2
  } pool_map_e;

  localparam int unsigned PAGE_W     = 3;
  localparam int unsigned OFF_W      = 6;
  localparam int unsigned PAGE_BYTES = 256;
  localparam int unsigned OFF_UNIT   = 4;
  localparam int unsigned LANES      = 4;

  function automatic int unsigned map_depth(pool_map_e m);
    case (m)
      MAP_PAGED:   return 2048;
      MAP_FIXED16: return 256;
      default:     return 512;
    endcase
  endfunction

  function automatic int unsigned map_stride(pool_map_e m);
    case (m)
      MAP_FIXED16: return 16;
      default:     return 32;
    endcase
  endfunction

endpackage

// File: rtl/pool_bank.sv
module pool_bank #(
  parameter int unsigned ROWS  = 64,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wd,
  output logic [7:0]       rd
);

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wd;
      rd <= mem[row];
    end
  end

endmodule

// File: rtl/pool_window_calc.sv
module pool_window_calc
  import pool_pkg::*;
#(
  parameter pool_map_e   MAP_MODE = MAP_PAGED,
  parameter int unsigned NUM_BUS  = 16,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned ADDR_W   = 11,
  localparam int unsigned BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int unsigned SUM_W   = ((ADDR_W > IDX_W) ? ADDR_W : IDX_W) + 3
) (
  input  logic [BUS_W-1:0]          bus_sel,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NUM_BUS*PAGE_W-1:0] page_vec,
  input  logic [NUM_BUS*OFF_W-1:0]  off_vec,
  output logic [ADDR_W-1:0]         addr
);

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    page = page_vec[bus_sel*PAGE_W +: PAGE_W];
    off  = off_vec[bus_sel*OFF_W +: OFF_W];
    if (MAP_MODE == MAP_PAGED) begin
      sum = SUM_W'(page) * SUM_W'(PAGE_BYTES)
          + SUM_W'(off) * SUM_W'(OFF_UNIT)
          + SUM_W'(idx);
    end else begin
      sum = SUM_W'(bus_sel) * SUM_W'(map_stride(MAP_MODE)) + SUM_W'(idx);
    end
    // depth is a power of two: keeping the low bits is the modulo
    addr = sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/pool_host_lanes.sv
module pool_host_lanes
  import pool_pkg::*;
#(
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned HOST_AW = 12,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned ROW_W  = ADDR_W - 2,
  localparam int unsigned HA_W   = HOST_AW + 1
) (
  input  logic                        req,
  input  logic                        we,
  input  logic [HOST_AW-1:0]          addr,
  input  logic [1:0]                  size,
  input  logic [31:0]                 wdata,
  output logic [LANES-1:0]            bank_en,
  output logic [LANES-1:0][ROW_W-1:0] bank_row,
  output logic [LANES-1:0][7:0]       bank_wd,
  output logic [LANES-1:0][1:0]       lane_bank,
  output logic [LANES-1:0]            lane_ok
);

  logic [HA_W-1:0] addr_x;
  assign addr_x = {1'b0, addr};

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [1:0]      lane;
    logic [HA_W-1:0] a_b;
    always_comb begin
      lane        = 2'(b) - addr[1:0];
      a_b         = addr_x + HA_W'(lane);
      bank_en[b]  = req && (lane <= size) && (a_b < HA_W'(DEPTH));
      bank_row[b] = a_b[ADDR_W-1:2];
      bank_wd[b]  = wdata[lane*8 +: 8];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [HA_W-1:0] a_i;
    always_comb begin
      a_i          = addr_x + HA_W'(i);
      lane_bank[i] = addr[1:0] + 2'(i);
      lane_ok[i]   = req && !we && (2'(i) <= size) && (a_i < HA_W'(DEPTH));
    end
  end

endmodule

// File: rtl/i2c_pool_sram.sv
module i2c_pool_sram
  import pool_pkg::*;
#(
  parameter pool_map_e   MAP_MODE = MAP_PAGED,
  parameter int unsigned NUM_BUS  = 16,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned HOST_AW  = 12,
  localparam int unsigned DEPTH   = map_depth(MAP_MODE),
  localparam int unsigned ADDR_W  = $clog2(DEPTH),
  localparam int unsigned ROW_W   = ADDR_W - 2,
  localparam int unsigned ROWS    = DEPTH / LANES,
  localparam int unsigned BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        host_req,
  input  logic                        host_we,
  input  logic [HOST_AW-1:0]          host_addr,
  input  logic [1:0]                  host_size,
  input  logic [31:0]                 host_wdata,
  output logic                        host_rvalid,
  output logic [31:0]                 host_rdata,
  input  logic                        eng_valid,
  output logic                        eng_ready,
  input  logic                        eng_we,
  input  logic [BUS_W-1:0]            eng_bus,
  input  logic [IDX_W-1:0]            eng_idx,
  input  logic [7:0]                  eng_wdata,
  output logic                        eng_rvalid,
  output logic [7:0]                  eng_rdata,
  input  logic [NUM_BUS*PAGE_W-1:0]   bus_page,
  input  logic [NUM_BUS*OFF_W-1:0]    bus_off
);

  logic [LANES-1:0]            h_en;
  logic [LANES-1:0][ROW_W-1:0] h_row;
  logic [LANES-1:0][7:0]       h_wd;
  logic [LANES-1:0][1:0]       lane_bank;
  logic [LANES-1:0]            lane_ok;
  logic [LANES-1:0][1:0]       lane_bank_q;
  logic [LANES-1:0]            lane_ok_q;
  logic [LANES-1:0][7:0]       bank_rd;
  logic [ADDR_W-1:0]           eng_addr;
  logic                        eng_go;
  logic [1:0]                  eng_bank_q;
  logic                        host_rvalid_q;
  logic                        eng_rvalid_q;

  pool_host_lanes #(.DEPTH(DEPTH), .HOST_AW(HOST_AW)) u_lanes (
    .req       (host_req),
    .we        (host_we),
    .addr      (host_addr),
    .size      (host_size),
    .wdata     (host_wdata),
    .bank_en   (h_en),
    .bank_row  (h_row),
    .bank_wd   (h_wd),
    .lane_bank (lane_bank),
    .lane_ok   (lane_ok)
  );

  pool_window_calc #(
    .MAP_MODE (MAP_MODE),
    .NUM_BUS  (NUM_BUS),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_window (
    .bus_sel  (eng_bus),
    .idx      (eng_idx),
    .page_vec (bus_page),
    .off_vec  (bus_off),
    .addr     (eng_addr)
  );

  // host has fixed priority over the engines
  assign eng_ready = !host_req;
  assign eng_go    = eng_valid && eng_ready;

  for (genvar b = 0; b < LANES; b++) begin : g_ram
    logic             en_b;
    logic             we_b;
    logic [ROW_W-1:0] row_b;
    logic [7:0]       wd_b;
    always_comb begin
      if (host_req) begin
        en_b  = h_en[b];
        we_b  = host_we;
        row_b = h_row[b];
        wd_b  = h_wd[b];
      end else begin
        en_b  = eng_go && (eng_addr[1:0] == 2'(b));
        we_b  = eng_we;
        row_b = eng_addr[ADDR_W-1:2];
        wd_b  = eng_wdata;
      end
    end
    pool_bank #(.ROWS(ROWS)) u_bank (
      .clk (clk),
      .en  (en_b),
      .we  (we_b),
      .row (row_b),
      .wd  (wd_b),
      .rd  (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid_q <= 1'b0;
      eng_rvalid_q  <= 1'b0;
      lane_ok_q     <= '0;
      lane_bank_q   <= '0;
      eng_bank_q    <= '0;
    end else begin
      host_rvalid_q <= host_req && !host_we;
      eng_rvalid_q  <= eng_go && !eng_we;
      if (host_req) begin
        lane_ok_q   <= lane_ok;
        lane_bank_q <= lane_bank;
      end
      if (eng_go) eng_bank_q <= eng_addr[1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      host_rdata[i*8 +: 8] = lane_ok_q[i] ? bank_rd[lane_bank_q[i]] : 8'h00;
    end
  end

  assign host_rvalid = host_rvalid_q;
  assign eng_rvalid  = eng_rvalid_q;
  assign eng_rdata   = bank_rd[eng_bank_q];

endmodule

// File: rtl/i2c_pool_sram_chk.sv
module i2c_pool_sram_chk #(
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned HOST_AW = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               host_req,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [1:0]         host_size,
  input logic               host_rvalid,
  input logic [31:0]        host_rdata,
  input logic               eng_valid,
  input logic               eng_ready,
  input logic               eng_we,
  input logic               eng_rvalid
);

  p_host_wins_r9: assert property (@(posedge clk) disable iff (rst)
    host_req |-> !eng_ready);

  p_engine_free_r9: assert property (@(posedge clk) disable iff (rst)
    !host_req |-> eng_ready);

  p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we) |=> host_rvalid);

  p_no_stray_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    !(host_req && !host_we) |=> !host_rvalid);

  p_single_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && host_size == 2'd0) |=> (host_rdata[31:8] == 24'h0));

  p_beyond_end_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && ({1'b0, host_addr} >= (HOST_AW+1)'(DEPTH))) |=> (host_rdata == 32'h0));

  p_eng_read_returns_r10: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && eng_ready && !eng_we) |=> eng_rvalid);

  p_eng_blocked_no_data_r9: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready && !host_we) |=> !eng_rvalid);

endmodule

bind i2c_pool_sram i2c_pool_sram_chk #(.DEPTH(DEPTH), .HOST_AW(HOST_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_size   (host_size),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata),
  .eng_valid   (eng_valid),
  .eng_ready   (eng_ready),
  .eng_we      (eng_we),
  .eng_rvalid  (eng_rvalid)
);

// File: tb/i2c_pool_sram_test.sv
module i2c_pool_sram_test;
  import pool_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        host_req = 0, host_we = 0;
  logic [11:0] host_addr = 0;
  logic [1:0]  host_size = 0;
  logic [31:0] host_wdata = 0;
  logic        eng_valid = 0, eng_we = 0;
  logic [3:0]  eng_bus = 0;
  logic [7:0]  eng_idx = 0, eng_wdata = 0;
  logic [NB*3-1:0] bus_page = '0;
  logic [NB*6-1:0] bus_off = '0;

  logic        h_rvalid [3];
  logic [31:0] h_rdata  [3];
  logic        e_ready  [3];
  logic        e_rvalid [3];
  logic [7:0]  e_rdata  [3];

  i2c_pool_sram #(.MAP_MODE(MAP_PAGED)) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rvalid(h_rvalid[0]), .host_rdata(h_rdata[0]),
    .eng_valid(eng_valid), .eng_ready(e_ready[0]), .eng_we(eng_we),
    .eng_bus(eng_bus), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .eng_rvalid(e_rvalid[0]), .eng_rdata(e_rdata[0]),
    .bus_page(bus_page), .bus_off(bus_off));

  i2c_pool_sram #(.MAP_MODE(MAP_FIXED16)) uut_f16 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rvalid(h_rvalid[1]), .host_rdata(h_rdata[1]),
    .eng_valid(eng_valid), .eng_ready(e_ready[1]), .eng_we(eng_we),
    .eng_bus(eng_bus), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .eng_rvalid(e_rvalid[1]), .eng_rdata(e_rdata[1]),
    .bus_page(bus_page), .bus_off(bus_off));

  i2c_pool_sram #(.MAP_MODE(MAP_FIXED32)) uut_f32 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rvalid(h_rvalid[2]), .host_rdata(h_rdata[2]),
    .eng_valid(eng_valid), .eng_ready(e_ready[2]), .eng_we(eng_we),
    .eng_bus(eng_bus), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .eng_rvalid(e_rvalid[2]), .eng_rdata(e_rdata[2]),
    .bus_page(bus_page), .bus_off(bus_off));

  // reference storage, one per mapping mode
  logic [7:0] m_p [2048];
  logic [7:0] m_16 [256];
  logic [7:0] m_32 [512];
  int pg [NB];
  int of [NB];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic int depth_of(int k);
    return (k == 0) ? 2048 : (k == 1) ? 256 : 512;
  endfunction

  function automatic logic [7:0] mget(int k, int a);
    if (a >= depth_of(k)) return 8'h00;
    case (k)
      0: return m_p[a];
      1: return m_16[a];
      default: return m_32[a];
    endcase
  endfunction

  function automatic void mput(int k, int a, logic [7:0] d);
    if (a >= depth_of(k)) return;
    case (k)
      0: m_p[a] = d;
      1: m_16[a] = d;
      default: m_32[a] = d;
    endcase
  endfunction

  function automatic logic [7:0] fillv(int a);
    return 8'((a * 37) + ((a >> 8) * 11) + 5);
  endfunction

  function automatic int eaddr(int k, int bus, int idx);
    case (k)
      0: return (pg[bus] * 256 + of[bus] * 4 + idx) % 2048;
      1: return (bus * 16 + idx) % 256;
      default: return (bus * 32 + idx) % 512;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input int s, input logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 12'(a); host_size = 2'(s); host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
    for (int k = 0; k < 3; k++)
      for (int i = 0; i <= s; i++) mput(k, a + i, d[i*8 +: 8]);
  endtask

  task automatic host_rd(input int a, input int s, input string req);
    logic [31:0] exp;
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = 12'(a); host_size = 2'(s);
    @(negedge clk);
    host_req = 0;
    for (int k = 0; k < 3; k++) begin
      exp = '0;
      for (int i = 0; i <= s; i++) exp[i*8 +: 8] = mget(k, a + i);
      check({req, " rvalid"}, 32'(h_rvalid[k]), 32'd1);
      check(req, h_rdata[k], exp);
    end
  endtask

  task automatic eng_op(input int bus, input int idx, input bit we, input logic [7:0] d,
                        input string req);
    @(negedge clk);
    eng_valid = 1; eng_we = we; eng_bus = 4'(bus); eng_idx = 8'(idx); eng_wdata = d;
    #1;
    for (int k = 0; k < 3; k++) check("R9 ready idle", 32'(e_ready[k]), 32'd1);
    @(negedge clk);
    eng_valid = 0; eng_we = 0;
    for (int k = 0; k < 3; k++) begin
      if (we) mput(k, eaddr(k, bus, idx), d);
      else begin
        check({req, " eng_rvalid"}, 32'(e_rvalid[k]), 32'd1);
        check(req, 32'(e_rdata[k]), 32'(mget(k, eaddr(k, bus, idx))));
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int n = 0; n < NB; n++) begin
      pg[n] = (n * 5 + 1) % 8;
      of[n] = (n * 11 + 3) % 64;
    end
    pg[15] = 7; of[15] = 63;  // 1792+252+idx overflows 2048
    for (int n = 0; n < NB; n++) begin
      bus_page[n*3 +: 3] = 3'(pg[n]);
      bus_off[n*6 +: 6]  = 6'(of[n]);
    end

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R1 host_rvalid reset", 32'(h_rvalid[k]), 32'd0);
      check("R1 eng_rvalid reset", 32'(e_rvalid[k]), 32'd0);
      check("R1 eng_ready reset", 32'(e_ready[k]), 32'd1);
    end

    // R4: words past each smaller depth must not alias onto low addresses
    for (int a = 0; a < 2048; a += 4)
      host_wr(a, 3, {fillv(a+3), fillv(a+2), fillv(a+1), fillv(a)});

    // R2 R4: every address, rotating sizes, across all three depths
    for (int a = 0; a < 2048; a++) host_rd(a, a % 4, "R2 sweep");
    host_rd(254, 3, "R4 end f16");
    host_rd(510, 3, "R4 end f32");
    host_rd(2046, 3, "R4 end paged");
    host_rd(3000, 3, "R4 far beyond");

    // R3: writes of every size at every alignment
    for (int a = 0; a < 40; a++)
      host_wr(a, (a * 3) % 4, 32'hA5000000 + 32'(a * 257));
    for (int a = 0; a < 44; a++) host_rd(a, 3, "R3 unaligned");

    // R4: writes straddling each end are clipped, no wrap to 0
    host_wr(254, 3, 32'h11223344);
    host_wr(510, 3, 32'h55667788);
    host_wr(2046, 3, 32'h99AABBCC);
    host_rd(0, 3, "R4 no wrap");
    host_rd(252, 3, "R4 clip f16");
    host_rd(508, 3, "R4 clip f32");
    host_rd(2044, 3, "R4 clip paged");

    // R5 R6 R7 R8: every bus, indices including overflowing ones
    for (int n = 0; n < NB; n++) begin
      foreach (pg[j]) begin end
      eng_op(n, 0, 0, 0, "R5 R6 R7 window base");
      eng_op(n, 1, 0, 0, "R5 R6 R7 idx1");
      eng_op(n, 3, 0, 0, "R5 R6 R7 idx3");
      eng_op(n, 17, 0, 0, "R5 R6 R7 idx17");
      eng_op(n, 100, 0, 0, "R8 idx100");
      eng_op(n, 255, 0, 0, "R8 idx255 wrap");
    end

    // R10: engine writes, read back through engine and host
    for (int n = 0; n < NB; n++) eng_op(n, n * 3 + 200, 1, 8'(n * 19 + 7), "R10 write");
    for (int n = 0; n < NB; n++) eng_op(n, n * 3 + 200, 0, 0, "R10 readback");
    for (int a = 0; a < 2048; a += 4) host_rd(a, 3, "R10 host view");

    // R9: host and engine in the same cycle
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = 12'd5; host_size = 2'd0;
    eng_valid = 1; eng_we = 0; eng_bus = 4'd2; eng_idx = 8'd9;
    #1;
    for (int k = 0; k < 3; k++) check("R9 ready low on clash", 32'(e_ready[k]), 32'd0);
    @(negedge clk);
    host_req = 0;
    #1;
    for (int k = 0; k < 3; k++) begin
      check("R9 host served", h_rdata[k], {24'h0, mget(k, 5)});
      check("R9 engine held", 32'(e_rvalid[k]), 32'd0);
      check("R9 ready after", 32'(e_ready[k]), 32'd1);
    end
    @(negedge clk);
    eng_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check("R9 engine served", 32'(e_rvalid[k]), 32'd1);
      check("R9 engine data", 32'(e_rdata[k]), 32'(mget(k, eaddr(k, 2, 9))));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule